// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates twelve interrupt request lines on behalf of a small 8-bit processor core. Each line has its own enable bit, and one global enable gates all of them. Each line also has a priority bit that puts it at the high or the low level. Within a level, the lowest-numbered line wins. The winner is offered to the core as a call request, together with its source number and a fixed vector address. The offer stays fixed until the core acknowledges it.

The controller keeps one in-service flag per level. An acknowledge sets the flag of the level that was taken. A return pulse from the core closes the innermost active level. A new call is offered only when the winning line's level is above every level now in service. So a low handler can be interrupted by a high request, and a high handler cannot be interrupted at all. The cycle after an acknowledge, the controller pulses a one-hot clear mask so that the external logic holding the request can drop the taken line.

The request lines are assumed to be conditioned already, for example edge-captured and held until cleared.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `call_req`, `svc_hi`, `svc_lo` and `req_clr` are all 0. All enables, all priorities and the global enable are 0.
- R2: A line can be offered only when its enable bit (written with `cfg_sel`=0) is 1 and the global enable (`cfg_wdata[0]` written with `cfg_sel`=2) is 1. `cfg_sel`=3 writes have no effect.
- R3: A candidate whose priority bit (written with `cfg_sel`=1, 1 = high) is set wins over every low candidate, whatever their indices.
- R4: Among candidates of the same level, the one with the lowest index wins.
- R5: While `call_req` is 1, `call_vec` equals 3 + 8 × `call_src`.
- R6: A call is raised one clock edge after an allowed candidate is seen while no call is pending. Once raised, `call_req`, `call_src` and `call_vec` stay unchanged until the edge at which `call_ack` is 1.
- R7: On an acknowledge edge, `call_req` falls and the in-service flag of the taken level is set. For the next cycle only, `req_clr` is one-hot at the taken source.
- R8: While only the low level is in service, a low candidate is never offered and a high candidate is.
- R9: While the high level is in service, no call is raised.
- R10: A `ret_pulse` edge clears `svc_hi` if it is set, and otherwise clears `svc_lo`. If an acknowledge happens on the same edge, its set wins for that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NSRC | Conditioned request lines, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 enables, 1 priorities, 2 global enable, 3 none |
| cfg_wdata | input | NSRC | Write data |
| call_ack | input | 1 | Core accepts the pending call |
| ret_pulse | input | 1 | Core returns from the current handler |
| call_req | output | 1 | Call request to the core |
| call_src | output | SRC_W | Index of the offered source |
| call_vec | output | VEC_W | Vector address of the offered source |
| svc_hi | output | 1 | High level in service |
| svc_lo | output | 1 | Low level in service |
| req_clr | output | NSRC | One-cycle one-hot clear for the taken source |

## Verification
The hardest state to reach is two-deep nesting. A low handler has to be in service, then a high request has to preempt it, and then the two returns have to unwind in the right order. A further request must be pending at every step to show that it is blocked or accepted. Directed sequences build exactly this nest with the low level in service, the high level in service, and both. Long random runs then mix configuration writes, acknowledges that arrive late, and returns that coincide with acknowledges. A cycle-level reference model in the bench checks every output on every cycle of those runs.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_PRIO   = 2'd1,
    SEL_GLOBAL = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs #(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pri_q,
  output logic            gie_q
);
  import nic_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pri_q <= '0;
      gie_q <= 1'b0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_ENABLE: en_q  <= wdata;
        SEL_PRIO:   pri_q <= wdata;
        SEL_GLOBAL: gie_q <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nic_first_set.sv
module nic_first_set #(
  parameter int N  = 12,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/nic_svc_track.sv
module nic_svc_track (
  input  logic clk,
  input  logic rst,
  input  logic set_hi,
  input  logic set_lo,
  input  logic ret,
  output logic hi_q,
  output logic lo_q
);
  logic hi_n, lo_n;

  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    if (ret) begin
      if (hi_q) hi_n = 1'b0;
      else      lo_n = 1'b0;
    end
    if (set_hi) hi_n = 1'b1;
    if (set_lo) lo_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NSRC     = 12,
  parameter int SRC_W    = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  irq_req,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [NSRC-1:0]  cfg_wdata,
  input  logic             call_ack,
  input  logic             ret_pulse,
  output logic             call_req,
  output logic [SRC_W-1:0] call_src,
  output logic [VEC_W-1:0] call_vec,
  output logic             svc_hi,
  output logic             svc_lo,
  output logic [NSRC-1:0]  req_clr
);
  logic [NSRC-1:0]  en_q, pri_q;
  logic             gie_q;
  logic [NSRC-1:0]  elig, hi_set, lo_set;
  logic             hi_found, lo_found;
  logic [SRC_W-1:0] hi_idx, lo_idx;
  logic             cand_hi, allowed, take, ack_now;
  logic [SRC_W-1:0] cand_idx;

  logic             call_req_q, call_hi_q;
  logic [SRC_W-1:0] call_src_q;
  logic [VEC_W-1:0] call_vec_q;
  logic [NSRC-1:0]  clr_q;

  nic_cfg_regs #(.NSRC(NSRC)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .en_q(en_q), .pri_q(pri_q), .gie_q(gie_q)
  );

  assign elig   = irq_req & en_q & {NSRC{gie_q}};
  assign hi_set = elig & pri_q;
  assign lo_set = elig & ~pri_q;

  nic_first_set #(.N(NSRC), .IW(SRC_W)) u_pick_hi (
    .vec(hi_set), .found(hi_found), .idx(hi_idx)
  );
  nic_first_set #(.N(NSRC), .IW(SRC_W)) u_pick_lo (
    .vec(lo_set), .found(lo_found), .idx(lo_idx)
  );

  assign cand_hi  = hi_found;
  assign cand_idx = hi_found ? hi_idx : lo_idx;
  assign allowed  = hi_found ? !svc_hi : (lo_found && !svc_hi && !svc_lo);
  assign take     = !call_req_q && allowed;
  assign ack_now  = call_req_q && call_ack;

  nic_svc_track u_svc (
    .clk(clk), .rst(rst),
    .set_hi(ack_now && call_hi_q),
    .set_lo(ack_now && !call_hi_q),
    .ret(ret_pulse),
    .hi_q(svc_hi), .lo_q(svc_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      call_req_q <= 1'b0;
      call_hi_q  <= 1'b0;
      call_src_q <= '0;
      call_vec_q <= '0;
      clr_q      <= '0;
    end else begin
      clr_q <= '0;
      if (ack_now) begin
        call_req_q <= 1'b0;
        clr_q      <= NSRC'(1) << call_src_q;
      end else if (take) begin
        call_req_q <= 1'b1;
        call_hi_q  <= cand_hi;
        call_src_q <= cand_idx;
        call_vec_q <= VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(cand_idx);
      end
    end
  end

  assign call_req = call_req_q;
  assign call_src = call_src_q;
  assign call_vec = call_vec_q;
  assign req_clr  = clr_q;
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
  parameter int NSRC     = 12,
  parameter int SRC_W    = 4,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             call_ack,
  input logic             call_req,
  input logic             call_hi,
  input logic [SRC_W-1:0] call_src,
  input logic [VEC_W-1:0] call_vec,
  input logic             svc_hi,
  input logic             svc_lo,
  input logic [NSRC-1:0]  req_clr
);
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (call_req && !call_ack) |=> (call_req && $stable(call_src) && $stable(call_vec)));
  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (call_req && call_ack) |=> (!call_req && $countones(req_clr) == 1));
  // R7
  clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_clr));
  // R5
  vec_map_chk: assert property (@(posedge clk) disable iff (rst)
    call_req |-> (call_vec == VEC_W'(VEC_BASE + VEC_STEP * int'(call_src))));
  // R9
  hi_block_chk: assert property (@(posedge clk) disable iff (rst)
    (svc_hi && !call_req) |=> !call_req);
  // R8
  lo_block_chk: assert property (@(posedge clk) disable iff (rst)
    (svc_lo && !call_req) |=> (!call_req || call_hi));
endmodule

bind nest_irq_ctrl nic_chk #(
  .NSRC(NSRC), .SRC_W(SRC_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_nic_chk (
  .clk(clk), .rst(rst), .call_ack(call_ack), .call_req(call_req),
  .call_hi(call_hi_q), .call_src(call_src), .call_vec(call_vec),
  .svc_hi(svc_hi), .svc_lo(svc_lo), .req_clr(req_clr)
);

// File: tb/test_nest_irq_ctrl.sv
`timescale 1ns/1ps
module test_nest_irq_ctrl;
  localparam int NSRC = 12;
  localparam int SW = 4;
  localparam int VW = 16;

  logic clk = 0, rst = 1;
  logic [NSRC-1:0] irq_req = '0, cfg_wdata = '0;
  logic cfg_we = 0, call_ack = 0, ret_pulse = 0;
  logic [1:0] cfg_sel = 0;
  logic call_req, svc_hi, svc_lo;
  logic [SW-1:0] call_src;
  logic [VW-1:0] call_vec;
  logic [NSRC-1:0] req_clr;

  int checks = 0, failures = 0, cycles = 0;

  nest_irq_ctrl #(.NSRC(NSRC)) i_nest_irq_ctrl (
    .clk(clk), .rst(rst), .irq_req(irq_req), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .call_ack(call_ack), .ret_pulse(ret_pulse),
    .call_req(call_req), .call_src(call_src), .call_vec(call_vec),
    .svc_hi(svc_hi), .svc_lo(svc_lo), .req_clr(req_clr)
  );

  always #4 clk = ~clk;

  // reference model state
  logic [NSRC-1:0] m_en = '0, m_pri = '0, m_clr = '0;
  logic m_gie = 0, m_req = 0, m_hi = 0, m_shi = 0, m_slo = 0;
  int m_src = 0;

  function automatic int lowest(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model();
    logic [NSRC-1:0] el;
    int h, l;
    bit ack, allow, nshi, nslo;
    if (rst) begin
      m_en = '0; m_pri = '0; m_gie = 0; m_req = 0; m_hi = 0;
      m_shi = 0; m_slo = 0; m_clr = '0; m_src = 0;
      return;
    end
    el = irq_req & m_en & {NSRC{m_gie}};
    h = lowest(el & m_pri);
    l = lowest(el & ~m_pri);
    allow = (h >= 0) ? !m_shi : (l >= 0 && !m_shi && !m_slo);
    ack = m_req && call_ack;
    nshi = m_shi; nslo = m_slo;
    if (ret_pulse) begin
      if (m_shi) nshi = 0; else nslo = 0;
    end
    if (ack && m_hi) nshi = 1;
    if (ack && !m_hi) nslo = 1;
    m_clr = '0;
    if (ack) begin
      m_req = 0;
      m_clr = NSRC'(1) << m_src;
    end else if (!m_req && allow) begin
      m_req = 1;
      m_hi = (h >= 0);
      m_src = (h >= 0) ? h : l;
    end
    m_shi = nshi; m_slo = nslo;
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: m_en = cfg_wdata;
        2'd1: m_pri = cfg_wdata;
        2'd2: m_gie = cfg_wdata[0];
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    check(call_req == m_req, "R6 call_req", call_req, m_req);
    if (m_req) begin
      check(call_src == SW'(m_src), "R4 call_src", call_src, m_src);
      check(call_vec == VW'(3 + 8 * m_src), "R5 call_vec", call_vec, 3 + 8 * m_src);
    end
    check(svc_hi == m_shi, "R10 svc_hi", svc_hi, m_shi);
    check(svc_lo == m_slo, "R10 svc_lo", svc_lo, m_slo);
    check(req_clr == m_clr, "R7 req_clr", req_clr, m_clr);
  endtask

  task automatic cyc();
    @(posedge clk);
    model();
    @(negedge clk);
    cycles++;
    if (!rst) compare();
    irq_req = irq_req & ~req_clr;
  endtask

  task automatic wr(input logic [1:0] s, input logic [NSRC-1:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    cyc();
    cfg_we = 0;
  endtask

  task automatic ack1(); call_ack = 1; cyc(); call_ack = 0; endtask
  task automatic ret1(); ret_pulse = 1; cyc(); ret_pulse = 0; endtask

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    check(call_req == 0 && svc_hi == 0 && svc_lo == 0 && req_clr == 0, "R1 reset state",
          {call_req, svc_hi, svc_lo}, 0);

    // R2: global enable off blocks everything
    wr(2'd0, 12'hfff);
    irq_req = 12'hfff;
    repeat (3) cyc();
    check(call_req == 0, "R2 global off", call_req, 0);
    // R2: a write with select 3 has no effect
    wr(2'd3, 12'hfff);
    repeat (2) cyc();
    check(call_req == 0, "R2 sel3 ignored", call_req, 0);
    wr(2'd0, 12'h010);
    wr(2'd2, 12'h001);
    cyc();
    check(call_req == 1 && call_src == 4, "R2 only enabled source", call_src, 4);
    repeat (2) cyc();
    check(call_req == 1 && call_src == 4, "R6 held until ack", call_src, 4);
    ack1();
    check(call_req == 0 && svc_lo == 1 && req_clr == 12'h010, "R7 ack effects",
          req_clr, 12'h010);
    cyc();
    check(req_clr == 0, "R7 clear is one cycle", req_clr, 0);

    // R8: low blocked while low in service, high preempts
    wr(2'd0, 12'hfff);
    repeat (2) cyc();
    check(call_req == 0, "R8 low blocked", call_req, 0);
    wr(2'd1, 12'h080);
    cyc();
    check(call_req == 1 && call_src == 7, "R8 high preempts", call_src, 7);
    check(call_vec == 16'd59, "R5 vector of 7", call_vec, 59);
    ack1();
    check(svc_hi == 1 && svc_lo == 1, "R7 nested flags", {svc_hi, svc_lo}, 3);

    // R9: nothing raised while high in service
    wr(2'd1, 12'hf00);
    repeat (3) cyc();
    check(call_req == 0, "R9 high blocks all", call_req, 0);
    ret1();
    check(svc_hi == 0 && svc_lo == 1, "R10 ret clears high first", {svc_hi, svc_lo}, 1);
    cyc();
    check(call_req == 1 && call_src == 8, "R3 high beats lower-index low", call_src, 8);
    ack1();
    ret1();
    irq_req = '0;
    ret1();
    check(svc_hi == 0 && svc_lo == 0, "R10 ret then clears low", {svc_hi, svc_lo}, 0);
    repeat (2) cyc();
    if (call_req) begin ack1(); ret1(); end

    // R4: lowest index in one level
    wr(2'd1, 12'h000);
    irq_req = 12'h024;
    cyc();
    check(call_req == 1 && call_src == 2, "R4 lowest index", call_src, 2);
    check(call_vec == 16'd19, "R5 vector of 2", call_vec, 19);
    ack1();
    irq_req = '0;
    ret1();

    // constrained random phase
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 6000; n++) begin
      irq_req = irq_req | (($urandom % 4 == 0) ? NSRC'($urandom) & NSRC'($urandom) : '0);
      cfg_we = ($urandom % 40 == 0);
      cfg_sel = 2'($urandom);
      cfg_wdata = NSRC'($urandom);
      if (cfg_sel == 2'd2) cfg_wdata[0] = ($urandom % 4 != 0);
      call_ack = call_req && ($urandom % 3 == 0);
      ret_pulse = (svc_hi || svc_lo) && ($urandom % 6 == 0);
      cyc();
    end
    cfg_we = 0; call_ack = 0; ret_pulse = 0;
    cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule